// File: doc/BRIEF.md
# Hot-Plug Reset and Bus-Sync Sequencer

This block sits between a backplane and a target card that can be inserted while the bus is running. From the backplane reset and the board health signal it makes the card's local active-low reset. After that reset is released, it keeps the target's bus tracking switched off until a minimum number of bus clocks has passed and a bus idle cycle has then been seen. This way a card that leaves reset in the middle of another master's transfer does not take a later FRAME# edge of that transfer as a transaction start.

The block also times the initialization window that follows reset release. While the window is open, every configuration access request gets a retry request back. When the window closes, an init-done flag rises and configuration accesses go through without a retry. Both time spans are parameters. The defaults are 5 clocks and 2^25 clocks, and a simulation can set them shorter.

Top module: `hotplug_reset_seq`

## Requirements
- R1: The local reset `loc_rst_n` is low whenever the backplane reset `bp_rst_n` is low or the board health input `brd_ok_n` is high (board not healthy).
- R2: Once both sources are released, `loc_rst_n` goes high on the second rising clock edge. It passes through a two-stage synchronizer.
- R3: If either source is asserted again, `loc_rst_n` falls at once, without waiting for a clock. `trk_en`, `init_done` and `cfg_retry` clear, and both timers start over when reset is released again.
- R4: `trk_en` stays low until at least FRAME_MIN rising edges (default 5) have occurred with `loc_rst_n` high. Idle cycles sampled on those edges are ignored.
- R5: After the FRAME_MIN-th edge, `trk_en` rises following the first rising edge on which both `frame_n` and `irdy_n` are sampled high (a bus idle cycle). A busy bus keeps it low for as long as it stays busy. A cycle with `frame_n` high and `irdy_n` low is not idle.
- R6: Once high, `trk_en` stays high until the next reset, whatever the bus does.
- R7: While `loc_rst_n` is high and `init_done` is low, `cfg_retry` follows `cfg_req` in the same cycle. `cfg_retry` is low during reset.
- R8: `init_done` rises after the INIT_CLKS-th rising edge (default 2^25) with `loc_rst_n` high, and stays high until the next reset.
- R9: While `init_done` is high, `cfg_retry` stays low whatever `cfg_req` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| bp_rst_n | input | 1 | Backplane reset, active low |
| brd_ok_n | input | 1 | Board health, active low (low = healthy) |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| cfg_req | input | 1 | Configuration access request strobe, active high |
| loc_rst_n | output | 1 | Local card reset, active low |
| trk_en | output | 1 | Bus tracking enable for the target |
| cfg_retry | output | 1 | Retry request for a configuration access |
| init_done | output | 1 | Initialization window has expired |

## Verification
The release sequence is driven against a bus that changes between three states: busy with both strobes low, the last data phase (FRAME# high with IRDY# low), and idle. This separates a design that accepts an idle cycle before or on the FRAME_MIN-th edge, or that treats the last data phase as idle, from one that waits for a true idle cycle after the minimum. The configuration request is switched on and off throughout. This shows that the retry follows the request only while the window is open, and the init-done edge is checked on the exact clock on which it should change. Both reset sources are asserted again in the middle of operation. This confirms that the clear is asynchronous and that a long busy stretch after the second release keeps tracking off.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD      = 2'd0,
    SEQ_WAIT_IDLE = 2'd1,
    SEQ_TRACK     = 2'd2
  } seq_state_e;

  function automatic int cnt_w(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/hps_rst_sync.sv
module hps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic src_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_nxt = 1'b1;
    end else begin : g_chain
      always_comb sync_nxt = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge src_n) begin
    if (!src_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/hps_win_timer.sv
module hps_win_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);

  localparam int W = hps_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         done_q, done_nxt;
  logic         cnt_en;

  assign cnt_en = !done_q;

  always_comb begin
    cnt_nxt  = cnt_q;
    done_nxt = done_q;
    if (cnt_en) begin
      cnt_nxt  = cnt_q + W'(1);
      done_nxt = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_nxt;
      done_q <= done_nxt;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/hps_track_gate.sv
module hps_track_gate
  import hps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gap_done,
  input  logic frame_n,
  input  logic irdy_n,
  output logic trk_en_o
);

  seq_state_e state_q, state_nxt;
  logic       bus_idle;

  assign bus_idle = frame_n && irdy_n;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      SEQ_HOLD: begin
        if (gap_done) state_nxt = bus_idle ? SEQ_TRACK : SEQ_WAIT_IDLE;
      end
      SEQ_WAIT_IDLE: begin
        if (bus_idle) state_nxt = SEQ_TRACK;
      end
      SEQ_TRACK: state_nxt = SEQ_TRACK;
      default:   state_nxt = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_HOLD;
    else        state_q <= state_nxt;
  end

  assign trk_en_o = (state_q == SEQ_TRACK);

endmodule

// File: rtl/hotplug_reset_seq.sv
module hotplug_reset_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_MIN   = 5,
  parameter int INIT_CLKS   = 33554432
) (
  input  logic clk,
  input  logic bp_rst_n,
  input  logic brd_ok_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic cfg_req,
  output logic loc_rst_n,
  output logic trk_en,
  output logic cfg_retry,
  output logic init_done
);

  logic src_n;
  logic rst_n_int;
  logic gap_done;
  logic win_done;

  // Reset held while backplane reset is low or the board is not healthy.
  assign src_n = bp_rst_n && !brd_ok_n;

  hps_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .src_n   (src_n),
    .rst_n_o (rst_n_int)
  );

  hps_win_timer #(.LIMIT(FRAME_MIN)) u_gap_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .done_o (gap_done)
  );

  hps_win_timer #(.LIMIT(INIT_CLKS)) u_init_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .done_o (win_done)
  );

  hps_track_gate u_track (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .gap_done (gap_done),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .trk_en_o (trk_en)
  );

  assign loc_rst_n = rst_n_int;
  assign init_done = win_done;
  assign cfg_retry = cfg_req && rst_n_int && !win_done;

endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
  parameter int FRAME_MIN = 5
) (
  input logic clk,
  input logic bp_rst_n,
  input logic brd_ok_n,
  input logic frame_n,
  input logic irdy_n,
  input logic cfg_req,
  input logic loc_rst_n,
  input logic trk_en,
  input logic cfg_retry,
  input logic init_done
);

  localparam int CW = hps_pkg::cnt_w(FRAME_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(FRAME_MIN + 1);

  logic [CW-1:0] up_cnt;

  always_ff @(posedge clk or negedge loc_rst_n) begin
    if (!loc_rst_n)          up_cnt <= '0;
    else if (up_cnt != CMAX) up_cnt <= up_cnt + CW'(1);
  end

  AST_RST_HELD: assert property (@(posedge clk)
    (!bp_rst_n || brd_ok_n) |-> !loc_rst_n); // R1

  AST_RST_CLEARS: assert property (@(posedge clk)
    !loc_rst_n |-> (!trk_en && !init_done && !cfg_retry)); // R3

  AST_NO_EARLY_TRACK: assert property (@(posedge clk) disable iff (!loc_rst_n)
    trk_en |-> (up_cnt > CW'(FRAME_MIN))); // R4

  AST_TRACK_ON_IDLE: assert property (@(posedge clk) disable iff (!loc_rst_n)
    $rose(trk_en) |-> $past(frame_n && irdy_n)); // R5

  AST_TRACK_STICKY: assert property (@(posedge clk) disable iff (!loc_rst_n)
    trk_en |=> trk_en); // R6

  AST_RETRY_IN_WINDOW: assert property (@(posedge clk) disable iff (!loc_rst_n)
    (cfg_req && !init_done) |-> cfg_retry); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!loc_rst_n)
    init_done |=> init_done); // R8

  AST_NO_RETRY_AFTER: assert property (@(posedge clk) disable iff (!loc_rst_n)
    init_done |-> !cfg_retry); // R9

endmodule

bind hotplug_reset_seq hps_checker #(.FRAME_MIN(FRAME_MIN)) u_hps_chk (
  .clk       (clk),
  .bp_rst_n  (bp_rst_n),
  .brd_ok_n  (brd_ok_n),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .cfg_req   (cfg_req),
  .loc_rst_n (loc_rst_n),
  .trk_en    (trk_en),
  .cfg_retry (cfg_retry),
  .init_done (init_done)
);

// File: tb/tb_hotplug_reset_seq.sv
module tb_hotplug_reset_seq;

  localparam int CLK_PER   = 10;
  localparam int FRAME_MIN = 5;
  localparam int INIT_CLKS = 40;
  localparam int NVEC      = 14;

  // {bp_rst_n, brd_ok_n, frame_n, irdy_n, cfg_req, exp_loc, exp_trk, exp_retry, exp_done}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_1_0_0_1_0_0_0_0,  // both sources asserted
    9'b1_1_0_0_1_0_0_0_0,  // board still unhealthy
    9'b1_0_0_0_0_0_0_0_0,  // released, sync stage 1
    9'b1_0_0_0_1_1_0_1_0,  // sync stage 2: reset deasserts
    9'b1_0_0_0_0_1_0_0_0,  // gap edge 1
    9'b1_0_0_0_1_1_0_1_0,  // gap edge 2
    9'b1_0_1_1_0_1_0_0_0,  // gap edge 3, idle ignored
    9'b1_0_0_0_0_1_0_0_0,  // gap edge 4
    9'b1_0_1_1_1_1_0_1_0,  // gap edge 5, idle ignored
    9'b1_0_1_0_0_1_0_0_0,  // last data phase: not idle
    9'b1_0_0_0_0_1_0_0_0,  // busy
    9'b1_0_1_1_1_1_1_1_0,  // idle after minimum: tracking on
    9'b1_0_0_0_0_1_1_0_0,  // busy, tracking held
    9'b1_0_0_1_1_1_1_1_0   // address phase, tracking held
  };

  logic clk;
  logic bp_rst_n, brd_ok_n, frame_n, irdy_n, cfg_req;
  logic loc_rst_n, trk_en, cfg_retry, init_done;

  int n_chk;
  int n_fail;

  hotplug_reset_seq #(
    .SYNC_STAGES (2),
    .FRAME_MIN   (FRAME_MIN),
    .INIT_CLKS   (INIT_CLKS)
  ) dut (
    .clk       (clk),
    .bp_rst_n  (bp_rst_n),
    .brd_ok_n  (brd_ok_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .cfg_req   (cfg_req),
    .loc_rst_n (loc_rst_n),
    .trk_en    (trk_en),
    .cfg_retry (cfg_retry),
    .init_done (init_done)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic b, input logic h, input logic f,
                       input logic i, input logic c);
    @(negedge clk);
    bp_rst_n = b; brd_ok_n = h; frame_n = f; irdy_n = i; cfg_req = c;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    bp_rst_n = 1'b0; brd_ok_n = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; cfg_req = 1'b0;
    #1;
    check("R1 reset at time zero", loc_rst_n, 1'b0);

    // Table walk: release sequence against a changing bus
    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][8], VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4]);
      tick();
      check($sformatf("R1/R2 loc_rst_n step %0d", k), loc_rst_n, VEC[k][3]);
      check($sformatf("R4/R5/R6 trk_en step %0d", k), trk_en, VEC[k][2]);
      check($sformatf("R7 cfg_retry step %0d", k), cfg_retry, VEC[k][1]);
      check($sformatf("R8 init_done step %0d", k), init_done, VEC[k][0]);
    end

    // Ten edges with reset high so far; run up to edge INIT_CLKS-1
    for (int e = 11; e < INIT_CLKS; e++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      tick();
    end
    check("R8 init_done low one edge early", init_done, 1'b0);
    check("R7 retry still given", cfg_retry, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    tick();
    check("R8 init_done on last edge", init_done, 1'b1);
    check("R9 no retry after window", cfg_retry, 1'b0);
    check("R6 tracking held on busy bus", trk_en, 1'b1);

    // Asynchronous reassertion of backplane reset
    @(negedge clk);
    #1 bp_rst_n = 1'b0;
    #1;
    check("R3 loc_rst_n falls without clock", loc_rst_n, 1'b0);
    check("R3 trk_en cleared", trk_en, 1'b0);
    check("R3 init_done cleared", init_done, 1'b0);
    check("R3 retry cleared in reset", cfg_retry, 1'b0);

    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    tick();
    check("R2 still in reset after first edge", loc_rst_n, 1'b0);
    tick();
    check("R2 released after second edge", loc_rst_n, 1'b1);
    check("R3 timer restarted, retry again", cfg_retry, 1'b1);

    // Long busy stretch well past the minimum
    for (int e = 0; e < 20; e++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      tick();
    end
    check("R5 busy bus keeps tracking off", trk_en, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    tick();
    check("R5 idle cycle enables tracking", trk_en, 1'b1);

    // Health drop reasserts reset at once
    @(negedge clk);
    #1 brd_ok_n = 1'b1;
    #1;
    check("R1 health loss asserts reset", loc_rst_n, 1'b0);
    check("R3 health loss clears tracking", trk_en, 1'b0);

    finish_run();
  end

endmodule